// File: doc/BRIEF.md
# Predicated Instruction Decoder

This block turns one 16-bit instruction word of a small load/store processor into the control signals the rest of the core needs. The outputs are an instruction class, the 6-bit ALU operation, the register numbers for source, destination, memory pointer and jump target, and the 8-bit immediate byte. It also drives six side-effect enables: register write, RAM read, RAM write, instruction-pointer load, condition-flag write and a qualifier that marks the flag write as a clear.

Every instruction word carries a predicate in its top bit. A predicated instruction takes effect only while the single condition flag is set. When the predicate fails, every enable is held low. The class and the raw fields still show what was decoded. Encodings with no defined meaning decode as a do-nothing instruction, and this includes ALU codes that are not in the operation table. The outputs are registered by default, which gives a one-cycle latency from `insn_i` to the outputs. A parameter can select a purely combinational path instead. The register file, the ALU datapath and the memories sit outside this block.

Top module: `tcd_decoder`

## Requirements
- R1: When bit 15 of the word is 1 and `cond_flag_i` is 0, all six enables are 0. When bit 15 is 0, the enables do not depend on `cond_flag_i`. When bit 15 is 1 and the flag is 1, the enables are those of the same word with bit 15 cleared.
- R2: A word with bit 14 set and a defined ALU code in bits 13:8 has class 1. Defined codes are 0 to 8 and 32 to 37. Codes 0 to 8 (bit 13 clear) raise only `reg_wr_o`. Codes 32 to 37 (bit 13 set) raise only `flag_wr_o`, and `reg_wr_o` is never 1 together with `flag_wr_o`.
- R3: A word with bit 14 set and an ALU code of 9 to 31 or 38 to 63 has class 0 and all enables low.
- R4: Bits 14:12 = 000 give class 2 (low-byte immediate load) and 001 give class 3 (high-byte immediate load). Each raises only `reg_wr_o`.
- R5: Bits 14:8 = 0100000 give class 4 (word load) with `ram_rd_o` and `reg_wr_o`. Bits 14:8 = 0100001 give class 5 (word store) with only `ram_wr_o`. `ram_rd_o` and `ram_wr_o` are never both 1.
- R6: Bits 14:8 = 0100010 give class 6 (jump) with only `ip_ld_o`. `ip_ld_o` is never 1 outside class 6.
- R7: Bits 14:8 = 0100110 give class 7 (clear flag) with `flag_wr_o` and `flag_clr_o`. If the predicate fails, both stay 0. `flag_clr_o` is never 1 without `flag_wr_o`.
- R8: Bits 14:8 = 0100111 (no-op), 0100011, 0100100, 0100101, 0101xxx and 011xxxx give class 0 and all enables low.
- R9: For every word, whatever its class, the fields come straight from the word: `alu_op_o` = bits 13:8, `imm_o` = bits 11:4, `src_reg_o` = `ptr_reg_o` = bits 7:4, and `dst_reg_o` = `jmp_reg_o` = bits 3:0.
- R10: With `REG_OUT` = 1, the outputs show the word and flag sampled at the previous rising clock edge. A synchronous active-high `rst` drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 16 | Instruction word |
| cond_flag_i | input | 1 | Current condition flag |
| class_o | output | 3 | Instruction class code (0 to 7) |
| alu_op_o | output | 6 | ALU operation field |
| src_reg_o | output | 4 | Source register number |
| dst_reg_o | output | 4 | Destination register number |
| ptr_reg_o | output | 4 | Memory-pointer register number |
| jmp_reg_o | output | 4 | Jump-target register number |
| imm_o | output | 8 | Immediate byte |
| reg_wr_o | output | 1 | Register-file write enable |
| ram_rd_o | output | 1 | RAM read enable |
| ram_wr_o | output | 1 | RAM write enable |
| ip_ld_o | output | 1 | Instruction-pointer load enable |
| flag_wr_o | output | 1 | Condition-flag write enable |
| flag_clr_o | output | 1 | Flag write is a clear (not an ALU compare result) |

## Verification
The bench builds the decoder with its default `REG_OUT` = 1, so the output register and the synchronous reset sit in the checked path. It applies all 65536 words with the flag at 0 and then at 1, one word per clock. This reaches every reserved pattern, every undefined ALU code and every predicated form of each class. Each cycle, the outputs are compared with a behavioural model of the word applied one clock earlier, and the bench asserts reset again at the end to check that every output clears.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int WORD_W   = 16;
  localparam int RIDX_W   = 4;
  localparam int IMM_W    = 8;
  localparam int AOP_W    = 6;
  localparam int CLS_W    = 3;
  localparam int EN_W     = 6;

  // field positions inside the instruction word
  localparam int PRED_BIT = WORD_W - 1;
  localparam int ALU_BIT  = WORD_W - 2;
  localparam int AOP_LSB  = 2 * RIDX_W;
  localparam int IMM_LSB  = RIDX_W;
  localparam int HI_RIDX  = RIDX_W;

  // largest defined ALU code in each half of the table
  localparam int ALU_PLAIN_MAX = 8;
  localparam int ALU_CMP_MAX   = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_IMM_LO = 3'd2,
    CLS_IMM_HI = 3'd3,
    CLS_LOAD   = 3'd4,
    CLS_STORE  = 3'd5,
    CLS_JUMP   = 3'd6,
    CLS_CLRF   = 3'd7
  } insn_class_e;

  typedef struct packed {
    logic [AOP_W-1:0]  aop;
    logic [RIDX_W-1:0] src;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] ptr;
    logic [RIDX_W-1:0] jmp;
    logic [IMM_W-1:0]  imm;
  } fields_t;

  typedef struct packed {
    logic reg_wr;
    logic ram_rd;
    logic ram_wr;
    logic ip_ld;
    logic flag_wr;
    logic flag_clr;
  } enables_t;

endpackage

// File: rtl/tcd_field_split.sv
module tcd_field_split
  import tcd_pkg::*;
(
  input  logic [ALU_BIT-1:0] body_i,
  output fields_t            fields_o
);

  always_comb begin
    fields_o.aop = body_i[AOP_LSB +: AOP_W];
    fields_o.imm = body_i[IMM_LSB +: IMM_W];
    fields_o.src = body_i[HI_RIDX +: RIDX_W];
    fields_o.ptr = body_i[HI_RIDX +: RIDX_W];
    fields_o.dst = body_i[0 +: RIDX_W];
    fields_o.jmp = body_i[0 +: RIDX_W];
  end

endmodule

// File: rtl/tcd_class_decode.sv
module tcd_class_decode
  import tcd_pkg::*;
(
  input  logic [PRED_BIT-1:0] op_i,
  output insn_class_e         class_o,
  output enables_t            raw_en_o
);

  logic [AOP_W-1:0] aop;
  logic             alu_defined;

  assign aop = op_i[AOP_LSB +: AOP_W];

  always_comb begin
    if (aop[AOP_W-1])
      alu_defined = (int'(aop[AOP_W-2:0]) <= ALU_CMP_MAX);
    else
      alu_defined = (int'(aop[AOP_W-2:0]) <= ALU_PLAIN_MAX);
  end

  always_comb begin
    class_o  = CLS_NONE;
    raw_en_o = '0;
    if (op_i[ALU_BIT]) begin
      if (alu_defined) begin
        class_o = CLS_ALU;
        if (aop[AOP_W-1]) raw_en_o.flag_wr = 1'b1;
        else              raw_en_o.reg_wr  = 1'b1;
      end
    end else begin
      unique case (op_i[ALU_BIT-1 -: 2])
        2'b00: begin
          class_o = CLS_IMM_LO;
          raw_en_o.reg_wr = 1'b1;
        end
        2'b01: begin
          class_o = CLS_IMM_HI;
          raw_en_o.reg_wr = 1'b1;
        end
        2'b10: begin
          if (!op_i[ALU_BIT-3]) begin
            unique case (op_i[AOP_LSB +: 3])
              3'b000: begin
                class_o = CLS_LOAD;
                raw_en_o.ram_rd = 1'b1;
                raw_en_o.reg_wr = 1'b1;
              end
              3'b001: begin
                class_o = CLS_STORE;
                raw_en_o.ram_wr = 1'b1;
              end
              3'b010: begin
                class_o = CLS_JUMP;
                raw_en_o.ip_ld = 1'b1;
              end
              3'b110: begin
                class_o = CLS_CLRF;
                raw_en_o.flag_wr  = 1'b1;
                raw_en_o.flag_clr = 1'b1;
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tcd_pred_gate.sv
module tcd_pred_gate
  import tcd_pkg::*;
(
  input  logic     pred_i,
  input  logic     flag_i,
  input  enables_t raw_en_i,
  output enables_t en_o
);

  logic            pass;
  logic [EN_W-1:0] raw_vec;
  logic [EN_W-1:0] gated_vec;

  assign pass    = !pred_i || flag_i;
  assign raw_vec = raw_en_i;

  for (genvar i = 0; i < EN_W; i++) begin : g_gate
    assign gated_vec[i] = raw_vec[i] & pass;
  end

  assign en_o = enables_t'(gated_vec);

endmodule

// File: rtl/tcd_decoder.sv
module tcd_decoder
  import tcd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] insn_i,
  input  logic              cond_flag_i,
  output logic [CLS_W-1:0]  class_o,
  output logic [AOP_W-1:0]  alu_op_o,
  output logic [RIDX_W-1:0] src_reg_o,
  output logic [RIDX_W-1:0] dst_reg_o,
  output logic [RIDX_W-1:0] ptr_reg_o,
  output logic [RIDX_W-1:0] jmp_reg_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              reg_wr_o,
  output logic              ram_rd_o,
  output logic              ram_wr_o,
  output logic              ip_ld_o,
  output logic              flag_wr_o,
  output logic              flag_clr_o
);

  fields_t     fields_c, fields_q;
  insn_class_e class_c,  class_q;
  enables_t    raw_en_c;
  enables_t    en_c,     en_q;

  tcd_field_split u_fields (
    .body_i   (insn_i[ALU_BIT-1:0]),
    .fields_o (fields_c)
  );

  tcd_class_decode u_class (
    .op_i     (insn_i[PRED_BIT-1:0]),
    .class_o  (class_c),
    .raw_en_o (raw_en_c)
  );

  tcd_pred_gate u_gate (
    .pred_i   (insn_i[PRED_BIT]),
    .flag_i   (cond_flag_i),
    .raw_en_i (raw_en_c),
    .en_o     (en_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        fields_q <= '0;
        class_q  <= CLS_NONE;
        en_q     <= '0;
      end else begin
        fields_q <= fields_c;
        class_q  <= class_c;
        en_q     <= en_c;
      end
    end

    assert_pred_block_R1: assert property (@(posedge clk) disable iff (rst)
      (insn_i[PRED_BIT] && !cond_flag_i) |=>
        !(reg_wr_o || ram_rd_o || ram_wr_o || ip_ld_o || flag_wr_o || flag_clr_o));
  end else begin : g_comb
    assign fields_q = fields_c;
    assign class_q  = class_c;
    assign en_q     = en_c;

    assert_pred_block_R1: assert property (@(posedge clk) disable iff (rst)
      (insn_i[PRED_BIT] && !cond_flag_i) |->
        !(reg_wr_o || ram_rd_o || ram_wr_o || ip_ld_o || flag_wr_o || flag_clr_o));
  end

  assign class_o    = class_q;
  assign alu_op_o   = fields_q.aop;
  assign src_reg_o  = fields_q.src;
  assign dst_reg_o  = fields_q.dst;
  assign ptr_reg_o  = fields_q.ptr;
  assign jmp_reg_o  = fields_q.jmp;
  assign imm_o      = fields_q.imm;
  assign reg_wr_o   = en_q.reg_wr;
  assign ram_rd_o   = en_q.ram_rd;
  assign ram_wr_o   = en_q.ram_wr;
  assign ip_ld_o    = en_q.ip_ld;
  assign flag_wr_o  = en_q.flag_wr;
  assign flag_clr_o = en_q.flag_clr;

  assert_reg_flag_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && flag_wr_o));

  assert_ram_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd_o && ram_wr_o));

  assert_jump_class_R6: assert property (@(posedge clk) disable iff (rst)
    ip_ld_o |-> (class_o == CLS_JUMP));

  assert_clr_needs_wr_R7: assert property (@(posedge clk) disable iff (rst)
    flag_clr_o |-> (flag_wr_o && class_o == CLS_CLRF));

  assert_none_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (class_o == CLS_NONE) |->
      !(reg_wr_o || ram_rd_o || ram_wr_o || ip_ld_o || flag_wr_o));

endmodule

// File: tb/tcd_decoder_tb.sv
module tcd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] insn = '0;
  logic        flag = 1'b0;

  logic [2:0] class_o;
  logic [5:0] alu_op_o;
  logic [3:0] src_reg_o, dst_reg_o, ptr_reg_o, jmp_reg_o;
  logic [7:0] imm_o;
  logic reg_wr_o, ram_rd_o, ram_wr_o, ip_ld_o, flag_wr_o, flag_clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tcd_decoder dut_i (
    .clk(clk), .rst(rst), .insn_i(insn), .cond_flag_i(flag),
    .class_o(class_o), .alu_op_o(alu_op_o),
    .src_reg_o(src_reg_o), .dst_reg_o(dst_reg_o),
    .ptr_reg_o(ptr_reg_o), .jmp_reg_o(jmp_reg_o), .imm_o(imm_o),
    .reg_wr_o(reg_wr_o), .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o),
    .ip_ld_o(ip_ld_o), .flag_wr_o(flag_wr_o), .flag_clr_o(flag_clr_o)
  );

  // behavioural model: class*64 + enables {reg,rd,wr,ip,fw,fc}
  function automatic int model(int w, int f);
    int op7 = (w >> 8) & 127;
    int aop = (w >> 8) & 63;
    int cls = 0;
    int en  = 0;
    if (op7 >= 64) begin
      if (aop <= 8)                     begin cls = 1; en = 32; end
      else if (aop >= 32 && aop <= 37)  begin cls = 1; en = 2;  end
    end else if (op7 < 16)  begin cls = 2; en = 32; end
    else if (op7 < 32)      begin cls = 3; en = 32; end
    else if (op7 == 32)     begin cls = 4; en = 48; end
    else if (op7 == 33)     begin cls = 5; en = 8;  end
    else if (op7 == 34)     begin cls = 6; en = 4;  end
    else if (op7 == 38)     begin cls = 7; en = 3;  end
    if (((w >> 15) & 1) == 1 && f == 0) en = 0;
    return cls * 64 + en;
  endfunction

  function automatic string tag_of(int w, int f);
    int op7 = (w >> 8) & 127;
    int aop = (w >> 8) & 63;
    if (((w >> 15) & 1) == 1 && f == 0) return "R1";
    if (op7 >= 64) return ((aop <= 8) || (aop >= 32 && aop <= 37)) ? "R2" : "R3";
    if (op7 < 32)  return "R4";
    if (op7 == 32 || op7 == 33) return "R5";
    if (op7 == 34) return "R6";
    if (op7 == 38) return "R7";
    return "R8";
  endfunction

  function automatic int got_ctrl();
    return int'(class_o) * 64 +
           int'({reg_wr_o, ram_rd_o, ram_wr_o, ip_ld_o, flag_wr_o, flag_clr_o});
  endfunction

  function automatic longint got_fields();
    return longint'({alu_op_o, imm_o, src_reg_o, ptr_reg_o, dst_reg_o, jmp_reg_o});
  endfunction

  function automatic longint exp_fields(int w);
    longint a = (w >> 8) & 63;
    longint i = (w >> 4) & 255;
    longint h = (w >> 4) & 15;
    longint l = w & 15;
    return (a << 30) | (i << 22) | (h << 18) | (h << 14) | (l << 10) | (l << 6) | (l << 2) | l;
  endfunction

  function automatic longint pack_fields_shape(longint v);
    return v;
  endfunction

  task automatic check_ctrl(int w, int f);
    int e = model(w, f);
    int g = got_ctrl();
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s word=%04h flag=%0d ctrl actual=%03h expected=%03h",
               tag_of(w, f), w, f, g, e);
    end
  endtask

  // R9: field routing; packed as {aop,imm,src,ptr,dst,jmp} widths 6,8,4,4,4,4
  task automatic check_fields(int w);
    longint g = got_fields();
    longint a = (w >> 8) & 63;
    longint i = (w >> 4) & 255;
    longint h = (w >> 4) & 15;
    longint l = w & 15;
    longint e = (a << 24) | (i << 16) | (h << 12) | (h << 8) | (l << 4) | l;
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL R9 word=%04h fields actual=%0h expected=%0h", w, g, e);
    end
  endtask

  task automatic check_reset_zero(string when);
    checks++;
    if (got_ctrl() !== 0 || got_fields() !== 0) begin
      fails++;
      $display("FAIL R10 %s reset outputs actual=%03h/%0h expected=000/0",
               when, got_ctrl(), got_fields());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(1_500_000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pw = 0;
    int pf = 0;
    bit have = 1'b0;
    // R10: reset state, inputs held at a word that would write a register
    insn = 16'h1234;
    flag = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_zero("initial");
    rst = 1'b0;
    // R1..R9: full sweep, flag 0 then 1; outputs lag inputs by one clock (R10)
    for (int f = 0; f < 2; f++) begin
      for (int w = 0; w < 65536; w++) begin
        @(negedge clk);
        if (have) begin
          check_ctrl(pw, pf);
          check_fields(pw);
        end
        insn = w[15:0];
        flag = f[0];
        pw = w;
        pf = f;
        have = 1'b1;
      end
    end
    @(negedge clk);
    check_ctrl(pw, pf);
    check_fields(pw);
    // R10: reset asserted mid-run clears outputs on the next edge
    insn = 16'h4000;
    flag = 1'b1;
    rst  = 1'b1;
    @(negedge clk);
    check_reset_zero("late");
    rst = 1'b0;
    @(negedge clk);
    check_ctrl(16'h4000, 1);
    check_fields(16'h4000);
    finish_run();
  end

endmodule